// File: doc/BRIEF.md
# Signed-Digit Cyclic Converter Code Assembler

This block sits behind a cyclic analog-to-digital converter that resolves 1.5 bits per step. On every conversion half-cycle the converter hands over the outputs of its two comparators. The block turns each comparator pair into a redundant digit of value -1, 0 or +1. It folds that digit into a running value by doubling the value and adding the digit. Because the digits are redundant, a comparator offset that pushes a decision across a threshold is absorbed by later steps, so the accumulated result stays correct without any trimming.

After the last of 13 digits, a fixed midscale offset is added, which gives an unsigned 14-bit code. The block then reduces that code to a 12-bit result at a gain of one, two or four, clamping at full scale. The result is announced with a one-cycle valid pulse. A start pulse opens each conversion and also aborts any conversion already in progress.

Top module: `adc_code_assembler`

## Requirements
- R1: The comparator pair (cmp_lo_i, cmp_hi_i) maps to a digit as follows: (0,0) gives -1, (1,0) gives 0, and (1,1) gives +1.
- R2: Each accepted step updates the accumulator as acc = 2*acc + d, starting from 0 at the start pulse. After 13 steps the code is acc + 8192, an unsigned 14-bit value from 1 to 16383.
- R3: valid_o is high for exactly one cycle, in the cycle after the clock edge that accepted the 13th step. result_o changes only at that edge and holds its value otherwise.
- R4: gain_i = 0 gives unity gain, with result_o = code >> 2.
- R5: gain_i = 1 gives a gain of two, with result_o = min(code >> 1, 4095).
- R6: gain_i = 2 or 3 gives a gain of four, with result_o = min(code, 4095). gain_i is sampled on the start pulse and held for that conversion.
- R7: The pair (0,1) on an accepted step counts as digit 0 and sets err_o. err_o then stays high until the next start pulse.
- R8: start_i clears the accumulator, the step count and err_o, and sets busy_o in the next cycle. A start pulse during a conversion discards the earlier steps. A step strobe in the same cycle as start_i is ignored.
- R9: A step strobe while busy_o is low is ignored: valid_o stays low and result_o keeps its value.
- R10: After reset, busy_o, valid_o and err_o are 0 and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new conversion |
| step_i | input | 1 | Strobe: comparator pair valid for one step |
| cmp_lo_i | input | 1 | Lower-threshold comparator output |
| cmp_hi_i | input | 1 | Upper-threshold comparator output |
| gain_i | input | 2 | Gain select: 0 = x1, 1 = x2, 2 or 3 = x4 |
| busy_o | output | 1 | A conversion is collecting steps |
| valid_o | output | 1 | One-cycle pulse: result_o is new |
| result_o | output | 12 | Scaled, saturated result |
| err_o | output | 1 | Sticky flag for an invalid comparator pair |

## Verification
Every output is registered exactly once. busy_o and a cleared err_o appear one cycle after start_i. err_o rises one cycle after the strobe that carries an invalid pair. valid_o and the new result_o appear one cycle after the 13th strobe. The bench drives inputs on the falling edge and samples on the next falling edge, which is the first point at which each of these registered effects is visible. It then samples once more to confirm that valid_o has dropped and result_o has held. Expected codes come from a bench function that applies the doubling recurrence, the offset and the gain clamp to the digits it sent.

// File: rtl/adc_code_pkg.sv
package adc_code_pkg;
  typedef enum logic [1:0] {
    GAIN_X1  = 2'd0,
    GAIN_X2  = 2'd1,
    GAIN_X4  = 2'd2,
    GAIN_X4B = 2'd3
  } gain_e;

  function automatic logic [1:0] gain_shift(input logic [1:0] g);
    case (g)
      GAIN_X1: gain_shift = 2'd0;
      GAIN_X2: gain_shift = 2'd1;
      default: gain_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/adc_digit_decode.sv
module adc_digit_decode (
  input  logic       cmp_lo_i,
  input  logic       cmp_hi_i,
  output logic [1:0] digit_o,   // two's complement -1/0/+1
  output logic       invalid_o
);
  always_comb begin
    invalid_o = 1'b0;
    unique case ({cmp_hi_i, cmp_lo_i})
      2'b00: digit_o = 2'b11;
      2'b01: digit_o = 2'b00;
      2'b11: digit_o = 2'b01;
      default: begin
        digit_o   = 2'b00;
        invalid_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/adc_step_accum.sv
module adc_step_accum #(
  parameter int unsigned NSTEPS = 13,
  localparam int unsigned CODE_W = NSTEPS + 1,
  localparam int unsigned CNT_W  = $clog2(NSTEPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [1:0]        digit_i,
  output logic              take_o,
  output logic              last_o,
  output logic              busy_o,
  output logic [CODE_W-1:0] code_o    // offset code for the step being taken
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CNT_W-1:0]  LAST = CNT_W'(NSTEPS - 1);

  logic [CODE_W-1:0] acc_q, acc_next;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;

  assign take_o   = busy_q && step_i && !start_i;
  assign last_o   = take_o && (cnt_q == LAST);
  assign acc_next = {acc_q[CODE_W-2:0], 1'b0} + {{(CODE_W-2){digit_i[1]}}, digit_i};
  assign code_o   = acc_next + MID;
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (take_o) begin
      acc_q <= acc_next;
      cnt_q <= cnt_q + CNT_W'(1);
      if (last_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_gain_scale.sv
module adc_gain_scale #(
  parameter int unsigned CODE_W    = 14,
  parameter int unsigned OUT_W     = 12,
  parameter int unsigned MAX_SHIFT = 2,
  localparam int unsigned WIDE_W   = CODE_W + MAX_SHIFT,
  localparam int unsigned SH_W     = $clog2(MAX_SHIFT + 1)
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic [OUT_W-1:0]  out_o
);
  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-(CODE_W-OUT_W)-1:0] top;

  assign wide = {{MAX_SHIFT{1'b0}}, code_i} << shift_i;
  assign top  = wide[WIDE_W-1:CODE_W-OUT_W];

  generate
    if (WIDE_W - (CODE_W - OUT_W) > OUT_W) begin : g_sat
      always_comb
        out_o = (|top[$bits(top)-1:OUT_W]) ? {OUT_W{1'b1}} : top[OUT_W-1:0];
    end else begin : g_nosat
      assign out_o = top[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/adc_code_assembler.sv
module adc_code_assembler #(
  parameter int unsigned NSTEPS = 13,
  parameter int unsigned OUT_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             cmp_lo_i,
  input  logic             cmp_hi_i,
  input  logic [1:0]       gain_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [OUT_W-1:0] result_o,
  output logic             err_o
);
  import adc_code_pkg::*;
  localparam int unsigned CODE_W = NSTEPS + 1;

  logic [1:0]        digit;
  logic              invalid, take, last;
  logic [CODE_W-1:0] code;
  logic [1:0]        gain_q;
  logic [OUT_W-1:0]  scaled;

  adc_digit_decode u_dec (
    .cmp_lo_i (cmp_lo_i),
    .cmp_hi_i (cmp_hi_i),
    .digit_o  (digit),
    .invalid_o(invalid)
  );

  adc_step_accum #(.NSTEPS(NSTEPS)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .step_i (step_i),
    .digit_i(digit),
    .take_o (take),
    .last_o (last),
    .busy_o (busy_o),
    .code_o (code)
  );

  adc_gain_scale #(.CODE_W(CODE_W), .OUT_W(OUT_W), .MAX_SHIFT(2)) u_scale (
    .code_i (code),
    .shift_i(gain_shift(gain_q)),
    .out_o  (scaled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q   <= '0;
      valid_o  <= 1'b0;
      result_o <= '0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= last;
      if (start_i) begin
        gain_q <= gain_i;
        err_o  <= 1'b0;
      end else if (take && invalid) begin
        err_o <= 1'b1;
      end
      if (last) result_o <= scaled;
    end
  end
endmodule

module adc_code_assembler_chk #(
  parameter int unsigned OUT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             step_i,
  input logic             busy_o,
  input logic             valid_o,
  input logic [OUT_W-1:0] result_o,
  input logic             err_o
);
  // R3
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R3
  valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && step_i && !start_i) |=> !valid_o);
  // R3
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));
  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);
  // R8
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && !err_o && !valid_o));
  // R9
  idle_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!valid_o && !busy_o));
endmodule

bind adc_code_assembler adc_code_assembler_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .step_i  (step_i),
  .busy_o  (busy_o),
  .valid_o (valid_o),
  .result_o(result_o),
  .err_o   (err_o)
);

// File: tb/adc_code_assembler_bench.sv
module adc_code_assembler_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, step_i = 1'b0, cmp_lo_i = 1'b0, cmp_hi_i = 1'b0;
  logic [1:0]  gain_i = 2'd0;
  logic        busy_o, valid_o, err_o;
  logic [11:0] result_o;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;
  logic [1:0] pairs [13];   // {hi,lo}

  always #2 clk_i = ~clk_i;

  adc_code_assembler u_adc_code_assembler (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .step_i(step_i),
    .cmp_lo_i(cmp_lo_i), .cmp_hi_i(cmp_hi_i), .gain_i(gain_i),
    .busy_o(busy_o), .valid_o(valid_o), .result_o(result_o), .err_o(err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int digit_of(input logic [1:0] p);
    case (p)
      2'b00: return -1;
      2'b11: return 1;
      default: return 0;   // 01 valid zero, 10 invalid -> zero
    endcase
  endfunction

  function automatic int expect_result(input int gain);
    int acc = 0, code, sh, r;
    for (int i = 0; i < 13; i++) acc = 2 * acc + digit_of(pairs[i]);
    code = acc + 8192;
    sh = (gain == 0) ? 0 : (gain == 1) ? 1 : 2;
    r = code >> (2 - sh);
    return (r > 4095) ? 4095 : r;
  endfunction

  task automatic do_start(input logic [1:0] g);
    @(negedge clk_i);
    start_i = 1'b1; gain_i = g;
    @(negedge clk_i);
    start_i = 1'b0; gain_i = ~g;   // later gain changes must not matter (R6)
  endtask

  task automatic do_step(input logic [1:0] p);
    step_i = 1'b1; cmp_hi_i = p[1]; cmp_lo_i = p[0];
    @(negedge clk_i);
    step_i = 1'b0;
  endtask

  // full conversion with optional random gaps; checks result and pulse shape
  task automatic run_conv(input logic [1:0] g, input bit gaps, input string req);
    int exp_v;
    do_start(g);
    chk("R8 busy after start", int'(busy_o), 1);
    for (int i = 0; i < 13; i++) begin
      if (gaps) begin
        int n = $urandom_range(0, 2);
        for (int k = 0; k < n; k++) @(negedge clk_i);
      end
      do_step(pairs[i]);
      if (i < 12) chk("R3 no early valid", int'(valid_o), 0);
    end
    exp_v = expect_result(int'(g));
    chk({req, " valid"}, int'(valid_o), 1);
    chk({req, " result"}, int'(result_o), exp_v);
    chk("R3 busy low after last", int'(busy_o), 0);
    @(negedge clk_i);
    chk("R3 single pulse", int'(valid_o), 0);
    chk("R3 result held", int'(result_o), exp_v);
  endtask

  task automatic fill(input logic [1:0] p);
    for (int i = 0; i < 13; i++) pairs[i] = p;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int held;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 valid", int'(valid_o), 0);
    chk("R10 err", int'(err_o), 0);
    chk("R10 result", int'(result_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R2 R4: all +1 -> code 16383
    fill(2'b11); run_conv(2'd0, 0, "R1 R2 R4 all plus");
    // all -1 -> code 1
    fill(2'b00); run_conv(2'd0, 0, "R1 R4 all minus");
    fill(2'b00); run_conv(2'd2, 0, "R6 all minus x4");
    fill(2'b00); run_conv(2'd1, 0, "R5 all minus x2");
    // all zero -> midscale 8192
    fill(2'b01); run_conv(2'd0, 0, "R1 R4 midscale");
    fill(2'b01); run_conv(2'd1, 0, "R5 midscale clamp x2");
    fill(2'b01); run_conv(2'd3, 0, "R6 midscale clamp gain3");
    // small code, unclamped at x4: digits -1 x11 then 0,+1
    fill(2'b00); pairs[11] = 2'b01; pairs[12] = 2'b11;
    run_conv(2'd2, 0, "R6 low code x4");
    run_conv(2'd1, 0, "R5 low code x2");
    chk("R7 no err on valid pairs", int'(err_o), 0);

    // R9: strobes while idle are ignored
    held = int'(result_o);
    for (int k = 0; k < 3; k++) begin
      step_i = 1'b1; cmp_hi_i = 1'b1; cmp_lo_i = 1'b1;
      @(negedge clk_i);
      chk("R9 idle valid", int'(valid_o), 0);
      chk("R9 idle result", int'(result_o), held);
    end
    step_i = 1'b0;

    // R7: invalid pair acts as 0 and latches err
    fill(2'b11); pairs[4] = 2'b10;
    do_start(2'd0);
    for (int i = 0; i < 13; i++) begin
      do_step(pairs[i]);
      if (i == 4) chk("R7 err set", int'(err_o), 1);
    end
    chk("R7 invalid as zero", int'(result_o), expect_result(0));
    @(negedge clk_i);
    chk("R7 err sticky", int'(err_o), 1);
    do_start(2'd0);
    chk("R8 start clears err", int'(err_o), 0);

    // R8: abort mid-conversion; start+step same cycle ignored
    for (int i = 0; i < 5; i++) do_step(2'b11);
    @(negedge clk_i);
    start_i = 1'b1; gain_i = 2'd0; step_i = 1'b1; cmp_hi_i = 1'b0; cmp_lo_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0; step_i = 1'b0;
    for (int i = 0; i < 13; i++) pairs[i] = (i % 2 == 0) ? 2'b11 : 2'b00;
    for (int i = 0; i < 13; i++) do_step(pairs[i]);
    chk("R8 abort valid", int'(valid_o), 1);
    chk("R8 abort result", int'(result_o), expect_result(0));
    @(negedge clk_i);

    // random conversions with gaps
    for (int t = 0; t < 40; t++) begin
      logic [1:0] g;
      for (int i = 0; i < 13; i++) begin
        int r = $urandom_range(0, 2);
        pairs[i] = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
      end
      g = 2'($urandom_range(0, 3));
      run_conv(g, 1, "R2 R4 R5 R6 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule